// File: doc/BRIEF.md
# Cache Victim Way Selector

This block decides which way of a four-way set-associative cache takes a new line after a read miss. For each miss it picks a candidate way by one of two policies: a rotating counter or a free-running pseudo-random sequence. It then lets a lockdown word adjust that candidate. The lockdown word can pin the fill to one way, or it can put a floor under the way number so that the lower ways are never replaced. The result comes out with a flat line index that addresses the tag and data arrays directly.

A test-mode input can stop allocation. When it is set, the block raises a bypass pulse instead of an allocate pulse, and the memory side serves the access without touching the cache. The tag RAM, the data RAM and the line-fill transfer sit outside this block. They take the allocate strobe, the way and the line index as their inputs.

Top module: `vsel_victim_select`

## Requirements
- R1: During and right after synchronous active-low reset, `alloc_vld`, `bypass_vld`, `alloc_way` and `alloc_line` are all zero, and the rotating counter starts at way 0.
- R2: The outputs are registered. A miss sampled at a clock edge shows its result on the outputs after that edge, for exactly one cycle. With no miss, neither strobe is raised.
- R3: With `rr_mode` = 1, the victim is the rotating count. On every allocating miss the count steps by one, modulo 4 (0, 1, 2, 3, 0, ...).
- R4: The rotating count holds its value on idle cycles, on bypassed misses and on misses allocated with `rr_mode` = 0.
- R5: With `rr_mode` = 0, the candidate is the low two bits of a free-running 16-bit maximal-length LFSR, seeded to 16'hACE1 at reset. Over a run of back-to-back misses, more than one way is chosen.
- R6: When bit 31 of `lock_reg` (the load flag) is 1, the victim is `lock_reg[1:0]`, whatever the policy gives. Such a miss still counts as an allocation for R3.
- R7: When bit 31 of `lock_reg` is 0, the victim is the policy candidate bitwise-ORed with `lock_reg[1:0]`. A zero word leaves the candidate unchanged.
- R8: `alloc_line` = {`miss_addr[7:5]`, victim way}. This is the set index (the address bits just above the 5-bit line offset) shifted left by two, plus the way.
- R9: When `fill_dis` = 1, a miss raises `bypass_vld` and not `alloc_vld`, and `alloc_way` and `alloc_line` keep their previous values.
- R10: `alloc_vld` and `bypass_vld` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_req | input | 1 | A read miss needs a victim this cycle |
| miss_addr | input | 32 | Byte address of the missing access |
| rr_mode | input | 1 | 1 = rotating replacement, 0 = pseudo-random |
| lock_reg | input | 32 | Lockdown word: bit 31 load flag, bits 1:0 way value |
| fill_dis | input | 1 | Test control: suppress allocation, serve from memory |
| alloc_vld | output | 1 | One-cycle strobe: allocate into `alloc_way` |
| alloc_way | output | 2 | Chosen victim way |
| alloc_line | output | 5 | Flat index into the tag and data arrays |
| bypass_vld | output | 1 | One-cycle strobe: serve the miss without allocating |

## Verification
A rotating counter that is wrong, or that advances on the wrong cycles, shows up as an unexpected `alloc_way` on the next allocating miss in rotating mode. The bench makes that miss right after each bypass, random-mode and lockdown phase, so a stray or missing step is seen within two cycles. A fault in the lockdown merge or the set-index slicing is visible on the very cycle after the miss, in `alloc_way` or the upper bits of `alloc_line`. A stuck pseudo-random source shows as a single repeated way across a run of random-mode misses.

// File: rtl/vsel_pkg.sv
// Package: vsel_pkg
// Shared constants for the victim selector: pseudo-random generator
// width, seed and feedback mask. Assumes a power-of-two way count elsewhere.
package vsel_pkg;
    localparam int          LFSR_W    = 16;
    // x^16 + x^14 + x^13 + x^11 + 1, right-shifting Galois form
    localparam logic [15:0] LFSR_TAPS = 16'hB400;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    typedef enum logic {
        POL_RANDOM = 1'b0,
        POL_ROTATE = 1'b1
    } policy_e;
endpackage

// File: rtl/vsel_lfsr.sv
// Module: vsel_lfsr
// Free-running Galois LFSR that steps on every clock outside reset.
// Assumes TAPS describes a maximal-length polynomial and SEED is nonzero.
module vsel_lfsr #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400,
    parameter logic [WIDTH-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] state
);
    logic [WIDTH-1:0] next_state;

    // Next state: shift right, fold in taps when the outgoing bit is 1
    always_comb begin
        next_state = state >> 1;
        if (state[0]) begin
            next_state = next_state ^ TAPS;
        end
    end

    // State register, loaded with the seed on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else begin
            state <= next_state;
        end
    end
endmodule

// File: rtl/vsel_rr_counter.sv
// Module: vsel_rr_counter
// Rotating way counter. Steps by one, modulo the number of ways, only
// when advance is high. Assumes the way count is a power of two.
module vsel_rr_counter #(
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [WAY_W-1:0] count
);
    // Counter register; natural wrap gives modulo-ways behaviour
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (advance) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/vsel_lock_merge.sv
// Module: vsel_lock_merge
// Combinational lockdown override. The top bit of the lockdown word
// forces the way. Otherwise the low way bits act as an OR floor on the
// policy candidate. Assumes LOCK_W > WAY_W.
module vsel_lock_merge #(
    parameter int WAY_W  = 2,
    parameter int LOCK_W = 32
) (
    input  logic [WAY_W-1:0]  candidate,
    input  logic [LOCK_W-1:0] lock_word,
    output logic [WAY_W-1:0]  victim
);
    localparam int LOAD_BIT = LOCK_W - 1;

    logic [WAY_W-1:0] lock_way;
    logic             load_flag;
    logic             lock_any;

    assign lock_way  = lock_word[WAY_W-1:0];
    assign load_flag = lock_word[LOAD_BIT];
    assign lock_any  = |lock_word;

    // Pick forced way, floored candidate, or plain candidate
    always_comb begin
        if (load_flag) begin
            victim = lock_way;
        end else if (lock_any) begin
            victim = candidate | lock_way;
        end else begin
            victim = candidate;
        end
    end
endmodule

// File: rtl/vsel_victim_select.sv
// Module: vsel_victim_select
// Victim way selector for a set-associative cache. It chooses a way for
// each read miss by rotating or pseudo-random policy, applies the lockdown
// override and registers the allocate or bypass decision with the flat line
// index. Assumes WAYS, LINE_BYTES and SETS are powers of two and that
// miss_req is high for one cycle per miss.
module vsel_victim_select
    import vsel_pkg::*;
#(
    parameter int  ADDR_W     = 32,
    parameter int  WAYS       = 4,
    parameter int  LINE_BYTES = 32,
    parameter int  SETS       = 8,
    parameter int  LOCK_W     = 32,
    localparam int WAY_W      = $clog2(WAYS),
    localparam int SET_W      = $clog2(SETS),
    localparam int LINE_W     = SET_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_req,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              rr_mode,
    input  logic [LOCK_W-1:0] lock_reg,
    input  logic              fill_dis,
    output logic              alloc_vld,
    output logic [WAY_W-1:0]  alloc_way,
    output logic [LINE_W-1:0] alloc_line,
    output logic              bypass_vld
);
    localparam int OFFSET_W = $clog2(LINE_BYTES);
    localparam int SET_LSB  = OFFSET_W;
    localparam int SET_MSB  = OFFSET_W + SET_W - 1;

    logic [LFSR_W-1:0] rand_state;
    logic [WAY_W-1:0]  rr_count;
    logic [WAY_W-1:0]  candidate;
    logic [WAY_W-1:0]  victim;
    logic [SET_W-1:0]  set_idx;
    logic              do_alloc;
    logic              do_bypass;
    policy_e           policy;
    logic              unused_addr_bits;
    logic              unused_rand_bits;

    vsel_lfsr #(
        .WIDTH (LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED)
    ) rand_i (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rand_state)
    );

    vsel_rr_counter #(
        .WAY_W (WAY_W)
    ) rr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (do_alloc && (policy == POL_ROTATE)),
        .count   (rr_count)
    );

    vsel_lock_merge #(
        .WAY_W  (WAY_W),
        .LOCK_W (LOCK_W)
    ) lock_i (
        .candidate (candidate),
        .lock_word (lock_reg),
        .victim    (victim)
    );

    assign policy    = rr_mode ? POL_ROTATE : POL_RANDOM;
    assign do_alloc  = miss_req && !fill_dis;
    assign do_bypass = miss_req && fill_dis;
    assign set_idx   = miss_addr[SET_MSB:SET_LSB];

    assign unused_addr_bits = ^{miss_addr[ADDR_W-1:SET_MSB+1], miss_addr[SET_LSB-1:0]};
    assign unused_rand_bits = ^rand_state[LFSR_W-1:WAY_W];

    // Policy candidate: rotating count or low bits of the random state
    always_comb begin
        case (policy)
            POL_ROTATE: candidate = rr_count;
            default:    candidate = rand_state[WAY_W-1:0];
        endcase
    end

    // Strobe registers: one-cycle allocate or bypass pulse per miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_vld  <= 1'b0;
            bypass_vld <= 1'b0;
        end else begin
            alloc_vld  <= do_alloc;
            bypass_vld <= do_bypass;
        end
    end

    // Result registers: updated only when a line is allocated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_way  <= '0;
            alloc_line <= '0;
        end else if (do_alloc) begin
            alloc_way  <= victim;
            alloc_line <= {set_idx, victim};
        end
    end
endmodule

// File: rtl/vsel_victim_checker.sv
// Module: vsel_victim_checker
// Property checker for the victim selector, bound to every instance.
// Assumes the same parameter values as the bound instance.
module vsel_victim_checker #(
    parameter int  ADDR_W     = 32,
    parameter int  WAYS       = 4,
    parameter int  LINE_BYTES = 32,
    parameter int  SETS       = 8,
    parameter int  LOCK_W     = 32,
    localparam int WAY_W      = $clog2(WAYS),
    localparam int SET_W      = $clog2(SETS),
    localparam int LINE_W     = SET_W + WAY_W,
    localparam int OFFSET_W   = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_req,
    input logic [ADDR_W-1:0] miss_addr,
    input logic [LOCK_W-1:0] lock_reg,
    input logic              fill_dis,
    input logic              alloc_vld,
    input logic [WAY_W-1:0]  alloc_way,
    input logic [LINE_W-1:0] alloc_line,
    input logic              bypass_vld
);
    logic unused_chk_bits;
    assign unused_chk_bits = ^{miss_addr, lock_reg};

    a_r2_alloc_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req && !fill_dis |=> alloc_vld && !bypass_vld);

    a_r2_quiet_without_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_req |=> !alloc_vld && !bypass_vld);

    a_r9_bypass_holds_result: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req && fill_dis |=> bypass_vld && !alloc_vld && $stable(alloc_way) && $stable(alloc_line));

    a_r6_load_flag_forces_way: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req && !fill_dis && lock_reg[LOCK_W-1]
        |=> alloc_way == $past(lock_reg[WAY_W-1:0]));

    a_r7_lock_floor_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req && !fill_dis && !lock_reg[LOCK_W-1]
        |=> (alloc_way & $past(lock_reg[WAY_W-1:0])) == $past(lock_reg[WAY_W-1:0]));

    a_r8_set_field: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req && !fill_dis
        |=> alloc_line[LINE_W-1 -: SET_W] == $past(miss_addr[OFFSET_W +: SET_W]));

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_vld && bypass_vld));
endmodule

bind vsel_victim_select vsel_victim_checker #(
    .ADDR_W     (ADDR_W),
    .WAYS       (WAYS),
    .LINE_BYTES (LINE_BYTES),
    .SETS       (SETS),
    .LOCK_W     (LOCK_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_req   (miss_req),
    .miss_addr  (miss_addr),
    .lock_reg   (lock_reg),
    .fill_dis   (fill_dis),
    .alloc_vld  (alloc_vld),
    .alloc_way  (alloc_way),
    .alloc_line (alloc_line),
    .bypass_vld (bypass_vld)
);

// File: tb/vsel_victim_select_tb.sv
`timescale 1ns/1ps
// Directed bench for vsel_victim_select: one task per scenario.
module vsel_victim_select_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_req = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        rr_mode = 1'b1;
    logic [31:0] lock_reg = '0;
    logic        fill_dis = 1'b0;
    logic        alloc_vld;
    logic [1:0]  alloc_way;
    logic [4:0]  alloc_line;
    logic        bypass_vld;

    int n_checks = 0;
    int n_fails  = 0;
    int rr_exp   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vsel_victim_select dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_req   (miss_req),
        .miss_addr  (miss_addr),
        .rr_mode    (rr_mode),
        .lock_reg   (lock_reg),
        .fill_dis   (fill_dis),
        .alloc_vld  (alloc_vld),
        .alloc_way  (alloc_way),
        .alloc_line (alloc_line),
        .bypass_vld (bypass_vld)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    function automatic int line_of(input logic [31:0] a, input int way);
        return int'(a[7:5]) * 4 + way;
    endfunction

    // One miss; outputs hold its result when the task returns
    task automatic do_miss(input logic [31:0] a, input logic rr,
                           input logic [31:0] lk, input logic fd);
        @(negedge clk);
        miss_req = 1'b1; miss_addr = a; rr_mode = rr; lock_reg = lk; fill_dis = fd;
        @(negedge clk);
        miss_req = 1'b0;
        if (!fd && rr) rr_exp = (rr_exp + 1) % 4;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rr_exp = 0;
        check("R1 alloc_vld", int'(alloc_vld), 0);
        check("R1 bypass_vld", int'(bypass_vld), 0);
        check("R1 alloc_way", int'(alloc_way), 0);
        check("R1 alloc_line", int'(alloc_line), 0);
    endtask

    task automatic t_round_robin;
        for (int i = 0; i < 6; i++) begin
            int way_exp;
            logic [31:0] a;
            way_exp = rr_exp;
            a = 32'h1000_0000 | (32'(i % 8) << 5) | 32'h4;
            do_miss(a, 1'b1, 32'h0, 1'b0);
            check("R3 rotating way", int'(alloc_way), way_exp);
            check("R2 alloc strobe", int'(alloc_vld), 1);
            check("R8 line index", int'(alloc_line), line_of(a, way_exp));
        end
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R2 strobe drops", int'(alloc_vld), 0);
        check("R2 no bypass idle", int'(bypass_vld), 0);
        repeat (5) @(negedge clk);
        do_miss(32'h0000_00E0, 1'b1, 32'h0, 1'b0);
        check("R4 idle keeps count", int'(alloc_way), (rr_exp + 3) % 4);
    endtask

    task automatic t_bypass;
        int prev_way, prev_line, way_exp;
        prev_way = int'(alloc_way);
        prev_line = int'(alloc_line);
        do_miss(32'h0000_0040, 1'b1, 32'h0, 1'b1);
        check("R9 bypass strobe", int'(bypass_vld), 1);
        check("R9 no alloc", int'(alloc_vld), 0);
        check("R10 exclusive", int'(alloc_vld && bypass_vld), 0);
        check("R9 way held", int'(alloc_way), prev_way);
        check("R9 line held", int'(alloc_line), prev_line);
        way_exp = rr_exp;
        do_miss(32'h0000_0060, 1'b1, 32'h0, 1'b0);
        check("R4 bypass keeps count", int'(alloc_way), way_exp);
    endtask

    task automatic t_lock_force;
        for (int w = 0; w < 4; w++) begin
            logic [31:0] a;
            a = 32'h2000_00A0;
            do_miss(a, 1'b1, 32'h8000_0000 | 32'(w), 1'b0);
            check("R6 forced way", int'(alloc_way), w);
            check("R8 forced line", int'(alloc_line), line_of(a, w));
        end
        do_miss(32'h0, 1'b0, 32'h8000_0002, 1'b0);
        check("R6 forced in random mode", int'(alloc_way), 2);
        begin
            int way_exp;
            way_exp = rr_exp;
            do_miss(32'h0, 1'b1, 32'h0, 1'b0);
            check("R6 load still advances count", int'(alloc_way), way_exp);
        end
    endtask

    task automatic t_lock_floor;
        for (int i = 0; i < 4; i++) begin
            int way_exp;
            way_exp = rr_exp | 1;
            do_miss(32'h0000_0020, 1'b1, 32'h0000_0001, 1'b0);
            check("R7 floor one", int'(alloc_way), way_exp);
        end
        for (int i = 0; i < 4; i++) begin
            int way_exp;
            way_exp = rr_exp | 2;
            do_miss(32'h0000_0020, 1'b1, 32'h0000_0002, 1'b0);
            check("R7 floor two", int'(alloc_way), way_exp);
        end
        begin
            int way_exp;
            way_exp = rr_exp;
            do_miss(32'h0000_0020, 1'b1, 32'h0001_0000, 1'b0);
            check("R7 zero low bits", int'(alloc_way), way_exp);
        end
    endtask

    task automatic t_random;
        logic [3:0] seen = '0;
        int way_exp;
        way_exp = rr_exp;
        for (int i = 0; i < 16; i++) begin
            do_miss(32'h0000_0080, 1'b0, 32'h0, 1'b0);
            seen[alloc_way] = 1'b1;
            check("R5 random alloc", int'(alloc_vld), 1);
        end
        check("R5 several ways", ($countones(seen) >= 2) ? 1 : 0, 1);
        do_miss(32'h0000_0080, 1'b1, 32'h0, 1'b0);
        check("R4 random keeps count", int'(alloc_way), way_exp);
    endtask

    initial begin
        t_reset();
        t_round_robin();
        t_idle();
        t_bypass();
        t_lock_force();
        t_lock_floor();
        t_random();
        t_reset();
        do_miss(32'h0000_00C0, 1'b1, 32'h0, 1'b0);
        check("R1 count restarts", int'(alloc_way), 0);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule